// File: doc/BRIEF.md
# Bit-Serial Elastic Store with Pointer Control

This block moves a framed, bit-serial TDM stream from a line-side write clock to a system-side read clock. Each written bit is stored in a circular two-frame buffer together with a tag that marks the first bit of a frame. The read side replays the bits in order and rebuilds its frame-sync from those tags. As a result, downstream logic stays frame-aligned whatever the read pointer does.

Four asynchronous controls shape the buffer. An enable routes the write stream straight to the outputs when it is low. A minimum-delay mode limits the working read/write separation to 32 bits. A reset command places the read pointer one full frame behind the write pointer. An align command pulls a read pointer that has come too close back to half a frame.

The write pointer crosses to the read domain in Gray code. All separation arithmetic and all pointer moves happen in the read domain. When the read pointer drifts into the guard band near the write pointer, a controlled slip repeats or skips half of the working depth. The slip is reported on a one-cycle flag.

Top module: `elastic_store`

## Requirements
- R1: With `ctl_enable` low, `rd_data` equals `wr_data` and `rd_fs` equals `wr_fs`, combinationally.
- R2: With `ctl_enable` high and equal clock rates, every written bit appears on `rd_data` in write order at a constant latency, with no slip. The write pointer changes at most one Gray-coded bit per write clock.
- R3: A 0-to-1 change on `ctl_reset` puts the read pointer one frame (FRAME_BITS = 256 bits) behind the synchronised write pointer. With equal clock rates, the bit seen on `rd_data` then trails the count of written bits by 256 + 3 (tolerance ±2).
- R4: With `ctl_min_delay` high, the working depth is 32 bits. A reset command then gives a separation of 16 bits, seen as a latency of 16 + 3 (±2).
- R5: A 0-to-1 change on `ctl_align` while the separation is below half a frame moves the read pointer to exactly half a frame behind. In normal mode that gives a latency of 128 + 3 (±2).
- R6: An align edge while the separation is at least half a frame leaves the latency unchanged.
- R7: Align acts only on a rising edge. Holding `ctl_align` high triggers nothing further.
- R8: When the read pointer comes within 4 bits of the write pointer, it repeats half the working depth. When it comes within 4 bits of the far end, it skips half the working depth. `rd_slip` pulses for one read cycle per slip, so 16 times the slip count tracks the read/write bit-count difference (±32) in minimum-delay mode.
- R9: `rd_fs` is high exactly on the read-out bit that was written with `wr_fs` high.
- R10: During `rst_n` low, with enable high, `rd_data`, `rd_fs` and `rd_slip` are 0. After release, the read pointer starts one frame behind (latency 254 to 260), with no slip.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| wr_clk | input | 1 | Line-side write clock |
| wr_data | input | 1 | Serial write data |
| wr_fs | input | 1 | High on the first bit of each written frame |
| rd_clk | input | 1 | System-side read clock |
| ctl_enable | input | 1 | 1 = buffer in path, 0 = bypass |
| ctl_min_delay | input | 1 | 1 = 32-bit working depth, 0 = two frames |
| ctl_align | input | 1 | Align command, rising-edge triggered |
| ctl_reset | input | 1 | Pointer reset command, rising-edge triggered |
| rd_data | output | 1 | Serial read data |
| rd_fs | output | 1 | High on the first bit of each frame read out |
| rd_slip | output | 1 | One-cycle pulse per controlled slip |

## Verification
A wrong read pointer after a command does not stay hidden. Within the first read bit after the pointers settle, the output stream stops matching the written stream at the required latency, and the bench's lag search lands on a different value. A corrupted Gray crossing or a separation sum with the wrong sign shows up as spurious `rd_slip` pulses within a few cycles at matched clock rates. A misplaced frame tag shows up as an `rd_fs` mismatch on the next frame boundary, at most 256 bits later.

// File: rtl/es_pkg.sv
`timescale 1ns/1ps
package es_pkg;
  // action taken on the read pointer in one read cycle
  typedef enum logic [2:0] {
    RP_STEP,
    RP_RESET,
    RP_ALIGN,
    RP_REPEAT,
    RP_SKIP
  } rp_act_e;

  // control inputs after synchronisation into the read domain
  typedef struct packed {
    logic min_delay;
    logic align;
    logic reset;
  } es_ctl_t;
endpackage

// File: rtl/es_sync.sv
`timescale 1ns/1ps
module es_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/es_wr_port.sv
`timescale 1ns/1ps
module es_wr_port #(
  parameter int AW = 9
) (
  input  logic          wr_clk,
  input  logic          rst_n,
  output logic [AW-1:0] wr_addr,
  output logic [AW-1:0] wr_gray
);
  localparam logic [AW-1:0] C_ONE = 1;

  function automatic logic [AW-1:0] bin_to_gray(input logic [AW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  logic [AW-1:0] addr_nxt;
  assign addr_nxt = wr_addr + C_ONE;

  always_ff @(posedge wr_clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_addr <= '0;
      wr_gray <= '0;
    end else begin
      wr_addr <= addr_nxt;
      wr_gray <= bin_to_gray(addr_nxt);
    end
  end

  // R2: the crossing word never changes more than one bit per write clock
  a_r2_gray_single_step: assert property (@(posedge wr_clk) disable iff (!rst_n)
    $countones(wr_gray ^ $past(wr_gray)) <= 1);
endmodule

// File: rtl/es_bitmem.sv
`timescale 1ns/1ps
module es_bitmem #(
  parameter int AW = 9
) (
  input  logic          wr_clk,
  input  logic [AW-1:0] wr_addr,
  input  logic [1:0]    wr_bits,
  input  logic          rd_clk,
  input  logic          rst_n,
  input  logic [AW-1:0] rd_addr,
  output logic [1:0]    rd_bits
);
  localparam int DEPTH = 1 << AW;

  // bit 0 = data, bit 1 = frame-start tag
  logic [1:0] ring [0:DEPTH-1];

  always_ff @(posedge wr_clk) begin
    ring[wr_addr] <= wr_bits;
  end

  always_ff @(posedge rd_clk or negedge rst_n) begin
    if (!rst_n) rd_bits <= '0;
    else        rd_bits <= ring[rd_addr];
  end
endmodule

// File: rtl/es_rd_ctrl.sv
`timescale 1ns/1ps
module es_rd_ctrl
  import es_pkg::*;
#(
  parameter int FRAME_BITS = 256,
  parameter int MIN_DEPTH  = 32,
  parameter int GUARD      = 4,
  parameter int AW         = 9
) (
  input  logic          rd_clk,
  input  logic          rst_n,
  input  logic [AW-1:0] wr_gray_s,
  input  es_ctl_t       ctl,
  output logic [AW-1:0] rd_addr,
  output logic          rd_slip
);
  localparam int FULL_DEPTH = 2 * FRAME_BITS;
  localparam logic [AW-1:0] C_ONE      = 1;
  localparam logic [AW-1:0] C_TWO      = 2;
  localparam logic [AW-1:0] C_GUARD    = GUARD[AW-1:0];
  localparam logic [AW-1:0] C_FRAME    = FRAME_BITS[AW-1:0];
  localparam logic [AW-1:0] C_HALF_FRM = FRAME_BITS[AW:1];
  localparam logic [AW-1:0] C_MIN_HALF = MIN_DEPTH[AW:1];
  localparam logic [AW-1:0] C_LIM_FULL = AW'(FULL_DEPTH - GUARD);
  localparam logic [AW-1:0] C_LIM_MIN  = AW'(MIN_DEPTH - GUARD);

  function automatic logic [AW-1:0] gray_to_bin(input logic [AW-1:0] g);
    logic [AW-1:0] b;
    b[AW-1] = g[AW-1];
    for (int i = AW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // read pointer after one cycle for a given action
  function automatic logic [AW-1:0] next_ptr(input rp_act_e a, input logic [AW-1:0] cur,
                                             input logic [AW-1:0] wb, input logic [AW-1:0] hd,
                                             input logic [AW-1:0] at);
    case (a)
      RP_RESET:  return wb - hd;
      RP_ALIGN:  return wb - at;
      RP_REPEAT: return cur + C_ONE - hd;
      RP_SKIP:   return cur + C_ONE + hd;
      default:   return cur + C_ONE;
    endcase
  endfunction

  logic [AW-1:0] rd_ptr;
  logic [AW-1:0] wr_bin;
  logic [AW-1:0] sep;
  logic [AW-1:0] half_depth;
  logic [AW-1:0] align_tgt;
  logic [AW-1:0] skip_lim;
  logic          align_d;
  logic          reset_d;
  logic          align_evt;
  logic          reset_evt;
  logic          slip_evt;
  logic          slip_q;
  rp_act_e       act;

  assign wr_bin     = gray_to_bin(wr_gray_s);
  assign sep        = wr_bin - rd_ptr;
  assign half_depth = ctl.min_delay ? C_MIN_HALF : C_FRAME;
  assign align_tgt  = ctl.min_delay ? C_MIN_HALF : C_HALF_FRM;
  assign skip_lim   = ctl.min_delay ? C_LIM_MIN : C_LIM_FULL;
  assign align_evt  = ctl.align & ~align_d;
  assign reset_evt  = ctl.reset & ~reset_d;

  always_comb begin
    if (reset_evt)                          act = RP_RESET;
    else if (align_evt && sep < align_tgt)  act = RP_ALIGN;
    else if (!slip_q && sep < C_GUARD)      act = RP_REPEAT;
    else if (!slip_q && sep > skip_lim)     act = RP_SKIP;
    else                                    act = RP_STEP;
  end

  assign slip_evt = (act == RP_REPEAT) || (act == RP_SKIP);

  always_ff @(posedge rd_clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr  <= C_FRAME;  // one frame behind a write pointer of zero
      slip_q  <= 1'b0;
      align_d <= 1'b0;
      reset_d <= 1'b0;
    end else begin
      rd_ptr  <= next_ptr(act, rd_ptr, wr_bin, half_depth, align_tgt);
      slip_q  <= slip_evt;
      align_d <= ctl.align;
      reset_d <= ctl.reset;
    end
  end

  assign rd_addr = rd_ptr;
  assign rd_slip = slip_q;

  // R3: after a reset command the separation is half the working depth (plus write advance)
  a_r3_reset_half_depth: assert property (@(posedge rd_clk) disable iff (!rst_n)
    (act == RP_RESET) |=> ((sep - $past(half_depth)) <= C_TWO));

  // R5: an acting align leaves the pointers half a frame apart
  a_r5_align_to_target: assert property (@(posedge rd_clk) disable iff (!rst_n)
    (act == RP_ALIGN) |=> ((sep - $past(align_tgt)) <= C_TWO));

  // R6: an align edge with enough separation only steps the read pointer
  a_r6_align_noop: assert property (@(posedge rd_clk) disable iff (!rst_n)
    (align_evt && !reset_evt && sep >= align_tgt && act == RP_STEP)
      |=> (rd_ptr == $past(rd_ptr) + C_ONE));

  // R8: a repeat restores at least the guard distance
  a_r8_repeat_restores: assert property (@(posedge rd_clk) disable iff (!rst_n)
    (act == RP_REPEAT) |=> (sep >= C_GUARD));
endmodule

// File: rtl/elastic_store.sv
`timescale 1ns/1ps
module elastic_store
  import es_pkg::*;
#(
  parameter int FRAME_BITS = 256,
  parameter int MIN_DEPTH  = 32,
  parameter int GUARD      = 4
) (
  input  logic rst_n,
  input  logic wr_clk,
  input  logic wr_data,
  input  logic wr_fs,
  input  logic rd_clk,
  input  logic ctl_enable,
  input  logic ctl_min_delay,
  input  logic ctl_align,
  input  logic ctl_reset,
  output logic rd_data,
  output logic rd_fs,
  output logic rd_slip
);
  localparam int AW = $clog2(2 * FRAME_BITS);

  logic [AW-1:0] wr_addr;
  logic [AW-1:0] wr_gray;
  logic [AW-1:0] wr_gray_s;
  logic [AW-1:0] rd_addr;
  logic [2:0]    ctl_raw;
  logic [2:0]    ctl_q;
  es_ctl_t       ctl_s;
  logic [1:0]    ring_q;

  es_wr_port #(.AW(AW)) u_wr (
    .wr_clk (wr_clk),
    .rst_n  (rst_n),
    .wr_addr(wr_addr),
    .wr_gray(wr_gray)
  );

  es_sync #(.W(AW)) u_ptr_sync (
    .clk  (rd_clk),
    .rst_n(rst_n),
    .d    (wr_gray),
    .q    (wr_gray_s)
  );

  assign ctl_raw = {ctl_min_delay, ctl_align, ctl_reset};

  es_sync #(.W(3)) u_ctl_sync (
    .clk  (rd_clk),
    .rst_n(rst_n),
    .d    (ctl_raw),
    .q    (ctl_q)
  );

  assign ctl_s = ctl_q;

  es_bitmem #(.AW(AW)) u_mem (
    .wr_clk (wr_clk),
    .wr_addr(wr_addr),
    .wr_bits({wr_fs, wr_data}),
    .rd_clk (rd_clk),
    .rst_n  (rst_n),
    .rd_addr(rd_addr),
    .rd_bits(ring_q)
  );

  es_rd_ctrl #(
    .FRAME_BITS(FRAME_BITS),
    .MIN_DEPTH (MIN_DEPTH),
    .GUARD     (GUARD),
    .AW        (AW)
  ) u_rd (
    .rd_clk   (rd_clk),
    .rst_n    (rst_n),
    .wr_gray_s(wr_gray_s),
    .ctl      (ctl_s),
    .rd_addr  (rd_addr),
    .rd_slip  (rd_slip)
  );

  // bypass path is combinational from the line side
  assign rd_data = ctl_enable ? ring_q[0] : wr_data;
  assign rd_fs   = ctl_enable ? ring_q[1] : wr_fs;
endmodule

// File: tb/elastic_store_bench.sv
`timescale 1ns/1ps
module elastic_store_bench;
  localparam int FRM   = 256;
  localparam int HISTN = 131072;

  logic rst_n = 1'b0;
  logic wr_clk = 1'b0;
  logic rd_clk = 1'b0;
  logic wr_data = 1'b0;
  logic wr_fs = 1'b0;
  logic ctl_enable = 1'b1;
  logic ctl_min_delay = 1'b0;
  logic ctl_align = 1'b0;
  logic ctl_reset = 1'b0;
  logic rd_data, rd_fs, rd_slip;

  bit  wbits [0:HISTN-1];
  bit  wfsb  [0:HISTN-1];
  int  wcount = 0;
  real wr_half = 4.0;
  int  nchk = 0;
  int  nerr = 0;
  bit  done = 0;

  elastic_store u_elastic_store (
    .rst_n(rst_n), .wr_clk(wr_clk), .wr_data(wr_data), .wr_fs(wr_fs),
    .rd_clk(rd_clk), .ctl_enable(ctl_enable), .ctl_min_delay(ctl_min_delay),
    .ctl_align(ctl_align), .ctl_reset(ctl_reset),
    .rd_data(rd_data), .rd_fs(rd_fs), .rd_slip(rd_slip)
  );

  initial forever #4 rd_clk = ~rd_clk;
  initial begin
    #3 wr_clk = 1'b1;
    forever #(wr_half) wr_clk = ~wr_clk;
  end

  always @(posedge wr_clk) if (rst_n) wcount <= wcount + 1;

  always @(negedge wr_clk) begin
    bit b;
    b = 1'($urandom % 2);
    wbits[wcount % HISTN] = b;
    wfsb[wcount % HISTN]  = (wcount % FRM == 0);
    wr_data = b;
    wr_fs   = (wcount % FRM == 0);
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic rclks(input int n);
    for (int i = 0; i < n; i++) @(negedge rd_clk);
  endtask

  task automatic pulse_reset();
    ctl_reset = 1'b1; rclks(4); ctl_reset = 1'b0;
  endtask

  // expected latency for a separation s: s + 1 (write advance) + 2 (sync and read register)
  function automatic int exp_lag(input int sep);
    return sep + 3;
  endfunction

  task automatic measure_lag(output int lag);
    bit sd [64]; bit sf [64]; int swc [64];
    for (int i = 0; i < 64; i++) begin
      @(negedge rd_clk);
      sd[i] = rd_data; sf[i] = rd_fs; swc[i] = wcount;
    end
    lag = -1;
    for (int l = 1; l < 700; l++) begin
      bit ok = 1;
      for (int i = 0; i < 64; i++) begin
        int idx = swc[i] - l;
        if (idx < 0) ok = 0;
        else if (wbits[idx % HISTN] != sd[i] || wfsb[idx % HISTN] != sf[i]) ok = 0;
      end
      if (ok && lag < 0) lag = l;
    end
  endtask

  task automatic watch(input int n, input int lag, output int dmis, output int fmis, output int slips);
    dmis = 0; fmis = 0; slips = 0;
    for (int i = 0; i < n; i++) begin
      int idx;
      @(negedge rd_clk);
      idx = wcount - lag;
      if (idx >= 0) begin
        if (rd_data != wbits[idx % HISTN]) dmis++;
        if (rd_fs != wfsb[idx % HISTN]) fmis++;
      end
      if (rd_slip) slips++;
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  endtask

  task automatic slip_phase(input real half, input string tag);
    int s0, w0, slips, dbl, prev, diff;
    wr_half = half;
    rclks(300);
    slips = 0; dbl = 0; prev = 0; w0 = wcount;
    for (int i = 0; i < 4000; i++) begin
      @(negedge rd_clk);
      if (rd_slip) begin
        slips++;
        if (prev) dbl++;
      end
      prev = rd_slip;
    end
    s0 = wcount - w0;
    diff = (4000 > s0) ? 4000 - s0 : s0 - 4000;
    check(slips >= 1, {"R8 slips occur ", tag}, slips, 1);
    check((16 * slips - diff <= 32) && (diff - 16 * slips <= 32),
          {"R8 slip count vs rate ", tag}, 16 * slips, diff);
    check(dbl == 0, {"R8 single-cycle slip pulse ", tag}, dbl, 0);
  endtask

  initial begin
    #1500000;
    nchk++; nerr++;
    $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    int lag0, lag3, lag5, lag6, lag7, lag8, lg, dm, fm, sl, bad;
    void'($urandom(32'd7321));

    // R10: reset state
    #50;
    check(rd_data == 1'b0 && rd_fs == 1'b0, "R10 outputs low in reset", int'(rd_data), 0);
    check(rd_slip == 1'b0, "R10 slip low in reset", int'(rd_slip), 0);
    #52 rst_n = 1'b1;
    sl = 0;
    for (int i = 0; i < 600; i++) begin @(negedge rd_clk); if (rd_slip) sl++; end
    check(sl == 0, "R10 no slip after reset", sl, 0);
    measure_lag(lag0);
    check(lag0 >= 254 && lag0 <= 260, "R10 start one frame behind", lag0, exp_lag(FRM) - 2);

    // R1: bypass
    ctl_enable = 1'b0;
    bad = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge wr_clk); #1;
      if (rd_data != wr_data || rd_fs != wr_fs) bad++;
    end
    check(bad == 0, "R1 bypass follows write side", bad, 0);
    ctl_enable = 1'b1;

    // R3: reset command
    rclks(10); pulse_reset(); rclks(700);
    measure_lag(lag3);
    check(lag3 >= exp_lag(FRM) - 2 && lag3 <= exp_lag(FRM) + 2, "R3 reset gives one frame", lag3, exp_lag(FRM));

    // R2 / R9: steady in-order stream
    watch(2000, lag3, dm, fm, sl);
    check(dm == 0, "R2 in-order constant latency", dm, 0);
    check(sl == 0, "R2 no slip at equal rates", sl, 0);
    check(fm == 0, "R9 frame sync tags", fm, 0);

    // R6: align with ample separation
    ctl_align = 1'b1; rclks(50);
    measure_lag(lag5);
    check(lag5 == lag3, "R6 align no-op", lag5, lag3);

    // R4: min-delay reset (align still held high)
    ctl_min_delay = 1'b1; rclks(100); pulse_reset(); rclks(100);
    measure_lag(lag6);
    check(lag6 >= exp_lag(16) - 2 && lag6 <= exp_lag(16) + 2, "R4 min-delay separation", lag6, exp_lag(16));
    watch(500, lag6, dm, fm, sl);
    check(dm == 0 && sl == 0, "R4 min-delay stream intact", dm + sl, 0);

    // R7: held align does not retrigger after leaving min-delay
    ctl_min_delay = 1'b0; rclks(100);
    measure_lag(lag7);
    check(lag7 == lag6, "R7 held align inert", lag7, lag6);

    // R5: fresh edge with small separation
    ctl_align = 1'b0; rclks(10); ctl_align = 1'b1; rclks(300);
    measure_lag(lag8);
    check(lag8 >= exp_lag(FRM / 2) - 2 && lag8 <= exp_lag(FRM / 2) + 2, "R5 align to half frame", lag8, exp_lag(FRM / 2));
    watch(300, lag8, dm, fm, sl);
    check(dm == 0 && fm == 0, "R9 tags after align", dm + fm, 0);
    ctl_align = 1'b0;

    // R3 / R4: random mode and reset sequence
    for (int it = 0; it < 6; it++) begin
      int m = int'($urandom % 2);
      int hd = m ? 16 : FRM;
      ctl_min_delay = m[0];
      rclks(60 + int'($urandom % 40)); pulse_reset(); rclks(700);
      measure_lag(lg);
      check(lg >= exp_lag(hd) - 2 && lg <= exp_lag(hd) + 2,
            m ? "R4 random reset min-delay" : "R3 random reset normal", lg, exp_lag(hd));
    end

    // R8: slips in min-delay mode, read faster then slower than write
    ctl_min_delay = 1'b1; rclks(50); pulse_reset(); rclks(100);
    slip_phase(4.25, "repeat");
    slip_phase(3.75, "skip");

    finish_run();
  end
endmodule